// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the register state that a 32-bit processor datapath works on. It shows sixteen architectural registers and the status words. The processor mode decides which physical copy stands behind an architectural index. Two combinational read ports and one clocked write port each take a 4-bit architectural index. Index 15 is the program counter. The datapath owns the program counter, so reads of index 15 return the datapath's value. A write to index 15 is passed out as a branch request and is not stored.

Storage covers every banked copy: thirty general words, one shared status word and five saved-status words. The external program counter brings the total to thirty-seven. The mode seen by the read ports is registered, so a mode change reaches the read ports one cycle late. A write always lands in the bank of the mode present at its clock edge. Access to the saved status word is gated: modes that have none read zero, raise an error flag on a read strobe and drop writes.

Top module: `banked_regfile`

## Requirements
- R1: After reset every stored general word, the shared status word and all saved-status words read zero, and the read side starts in Supervisor mode (10011), so spsr_present is 1.
- R2: Indices 0 to 7 name one physical word each, the same in every mode. A value written in any mode is read back in any other mode.
- R3: Indices 8 to 12 have a private copy in FIQ mode (10001). All other modes share the User copy.
- R4: Indices 13 and 14 have private copies in each of FIQ, IRQ (10010), Supervisor (10011), Abort (10111) and Undefined (11011). User (10000), System (11111) and any unlisted encoding share one copy.
- R5: A read of index 15 returns pc_in. A write to index 15 raises pc_wr_valid with pc_wr_data equal to wr_data in the same cycle and changes no stored word.
- R6: The shared status word is the same in every mode. A cpsr_we write shows on cpsr_q from the next cycle, and cpsr_q holds otherwise.
- R7: Each of FIQ, IRQ, Supervisor, Abort and Undefined has its own saved-status word, and spsr_present is 1 in those modes.
- R8: In User, System or an unlisted mode, spsr_present is 0, spsr_q reads zero, spsr_err equals spsr_rd, and spsr_we writes are dropped.
- R9: A read of an index written in the same cycle returns the old value. The new value shows from the next cycle.
- R10: Read ports, spsr_q, spsr_present and spsr_err follow the mode sampled at the previous clock edge. Writes use the mode present at the writing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 5 | Current processor mode encoding |
| pc_in | input | 32 | Program counter value from the datapath |
| ra_idx | input | 4 | Read port A architectural index |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B architectural index |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write architectural index |
| wr_data | input | 32 | Write data |
| pc_wr_valid | output | 1 | Write to index 15 seen this cycle |
| pc_wr_data | output | 32 | New program counter value |
| cpsr_we | input | 1 | Shared status word write enable |
| cpsr_wdata | input | 32 | Shared status word write data |
| cpsr_q | output | 32 | Shared status word |
| spsr_rd | input | 1 | Saved status word read strobe |
| spsr_we | input | 1 | Saved status word write enable |
| spsr_wdata | input | 32 | Saved status word write data |
| spsr_q | output | 32 | Saved status word of the current mode |
| spsr_present | output | 1 | Current mode has a saved status word |
| spsr_err | output | 1 | Saved status read attempted in a mode without one |

## Verification
A wrong bank mapping stores a value in the wrong physical word. It shows only when a later read in some mode reaches either that word or the word that should have changed, which can be many cycles after the write. The bench therefore keeps one view per mode and mixes modes freely, so cross-mode leaks appear on the next read of the affected index. A wrong registered mode shows in the very cycle after a mode change, on spsr_present and on banked reads.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      mode,
  input  logic [XLEN-1:0] pc_in,
  input  logic [3:0]      ra_idx,
  output logic [XLEN-1:0] ra_data,
  input  logic [3:0]      rb_idx,
  output logic [XLEN-1:0] rb_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  output logic            pc_wr_valid,
  output logic [XLEN-1:0] pc_wr_data,
  input  logic            cpsr_we,
  input  logic [XLEN-1:0] cpsr_wdata,
  output logic [XLEN-1:0] cpsr_q,
  input  logic            spsr_rd,
  input  logic            spsr_we,
  input  logic [XLEN-1:0] spsr_wdata,
  output logic [XLEN-1:0] spsr_q,
  output logic            spsr_present,
  output logic            spsr_err
);
  localparam int NGPR = 30;
  localparam int NSAVED = 5;
  localparam logic [4:0] M_FIQ = 5'b10001, M_IRQ = 5'b10010, M_SVC = 5'b10011,
                         M_ABT = 5'b10111, M_UND = 5'b11011;
  localparam logic [2:0] NO_SAVED = 3'd7;

  logic [XLEN-1:0] gpr   [NGPR];
  logic [XLEN-1:0] saved [NSAVED];
  logic [XLEN-1:0] cpsr_r;
  logic [4:0]      mode_q;

  // Layout: 0-14 User, 15-21 FIQ r8-r14, then r13/r14 pairs for IRQ, SVC, ABT, UND.
  function automatic logic [4:0] phys(input logic [4:0] m, input logic [3:0] r);
    if (r < 4'd8)  return {1'b0, r};
    if (m == M_FIQ) return 5'(r + 7);
    if (r < 4'd13) return {1'b0, r};
    case (m)
      M_IRQ:   return 5'(r + 9);
      M_SVC:   return 5'(r + 11);
      M_ABT:   return 5'(r + 13);
      M_UND:   return 5'(r + 15);
      default: return {1'b0, r};
    endcase
  endfunction

  function automatic logic [2:0] saved_sel(input logic [4:0] m);
    case (m)
      M_FIQ:   return 3'd0;
      M_IRQ:   return 3'd1;
      M_SVC:   return 3'd2;
      M_ABT:   return 3'd3;
      M_UND:   return 3'd4;
      default: return NO_SAVED;
    endcase
  endfunction

  logic [2:0] rd_sel, wr_sel;
  assign rd_sel = saved_sel(mode_q);
  assign wr_sel = saved_sel(mode);

  assign ra_data = (ra_idx == 4'd15) ? pc_in : gpr[phys(mode_q, ra_idx)];
  assign rb_data = (rb_idx == 4'd15) ? pc_in : gpr[phys(mode_q, rb_idx)];

  assign pc_wr_valid = wr_en && (wr_idx == 4'd15);
  assign pc_wr_data  = wr_data;

  assign cpsr_q       = cpsr_r;
  assign spsr_present = (rd_sel != NO_SAVED);
  assign spsr_q       = spsr_present ? saved[rd_sel] : '0;
  assign spsr_err     = spsr_rd && !spsr_present;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NGPR; i++) gpr[i] <= '0;
      for (int i = 0; i < NSAVED; i++) saved[i] <= '0;
      cpsr_r <= '0;
      mode_q <= M_SVC;
    end else begin
      mode_q <= mode;
      if (wr_en && wr_idx != 4'd15) gpr[phys(mode, wr_idx)] <= wr_data;
      if (cpsr_we) cpsr_r <= cpsr_wdata;
      if (spsr_we && wr_sel != NO_SAVED) saved[wr_sel] <= spsr_wdata;
    end
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      mode,
  input logic [3:0]      ra_idx,
  input logic [XLEN-1:0] ra_data,
  input logic            wr_en,
  input logic [3:0]      wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic            cpsr_we,
  input logic [XLEN-1:0] cpsr_wdata,
  input logic [XLEN-1:0] cpsr_q,
  input logic [XLEN-1:0] spsr_q,
  input logic            spsr_present,
  input logic            spsr_err
);
  a_r6_cpsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cpsr_we |=> $stable(cpsr_q));
  a_r6_cpsr_write: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_we |=> cpsr_q == $past(cpsr_wdata));
  a_r8_absent_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !spsr_present |-> spsr_q == '0);
  a_r8_err_only_absent: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_err |-> !spsr_present);
  a_r10_user_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 5'b10000 || mode == 5'b11111) |=> !spsr_present);
  a_r2_low_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < 4'd8) |=> (ra_idx != $past(wr_idx) || ra_data == $past(wr_data)));
endmodule

bind banked_regfile banked_regfile_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
  logic        clk = 0, rst_n = 0;
  logic [4:0]  mode = 5'b10011;
  logic [31:0] pc_in = 0, wr_data = 0, cpsr_wdata = 0, spsr_wdata = 0;
  logic [3:0]  ra_idx = 0, rb_idx = 0, wr_idx = 0;
  logic        wr_en = 0, cpsr_we = 0, spsr_rd = 0, spsr_we = 0;
  logic [31:0] ra_data, rb_data, pc_wr_data, cpsr_q, spsr_q;
  logic        pc_wr_valid, spsr_present, spsr_err;

  int nchk = 0, nerr = 0;
  bit done = 0;

  banked_regfile i_banked_regfile (.*);

  always #10 clk = ~clk;

  logic [31:0] view [7][15];
  logic [31:0] msaved [7];
  logic [31:0] mcpsr;
  int mq;

  localparam logic [4:0] CODES [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                       5'b10111, 5'b11011, 5'b11111, 5'b01010};

  function automatic int mi(logic [4:0] m);
    case (m)
      5'b10001: return 1; 5'b10010: return 2; 5'b10011: return 3;
      5'b10111: return 4; 5'b11011: return 5; default: return 0;
    endcase
  endfunction

  function automatic int grp(int m);
    return (m == 6) ? 0 : m;
  endfunction

  function automatic bit same_copy(int a, int b, int r);
    if (r < 8) return 1;
    if (r < 13) return (a == 1) == (b == 1);
    return grp(a) == grp(b);
  endfunction

  function automatic string rtag(int r, bit chg, bit coll);
    if (coll) return "R9";
    if (chg && r >= 8 && r < 15) return "R10";
    if (r < 8) return "R2";
    if (r < 13) return "R3";
    if (r < 15) return "R4";
    return "R5";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reset_model();
    for (int m = 0; m < 7; m++) begin
      for (int r = 0; r < 15; r++) view[m][r] = '0;
      msaved[m] = '0;
    end
    mcpsr = '0;
    mq = 3;
  endtask

  task automatic compare();
    bit chg, pres;
    chg  = (mi(mode) != mq) || (mode == 5'b11111) != (mq == 6);
    pres = (mq >= 1 && mq <= 5);
    check(rtag(ra_idx, chg, wr_en && wr_idx == ra_idx && ra_idx != 15), ra_data,
          ra_idx == 15 ? pc_in : view[mq][ra_idx]);
    check(rtag(rb_idx, chg, wr_en && wr_idx == rb_idx && rb_idx != 15), rb_data,
          rb_idx == 15 ? pc_in : view[mq][rb_idx]);
    check("R5", {31'b0, pc_wr_valid}, {31'b0, wr_en && wr_idx == 15});
    if (pc_wr_valid) check("R5", pc_wr_data, wr_data);
    check("R6", cpsr_q, mcpsr);
    check(chg ? "R10" : (pres ? "R7" : "R8"), {31'b0, spsr_present}, {31'b0, pres});
    check(pres ? "R7" : "R8", spsr_q, pres ? msaved[mq] : 32'h0);
    check("R8", {31'b0, spsr_err}, {31'b0, spsr_rd && !pres});
  endtask

  task automatic update();
    int wm;
    wm = (mode == 5'b11111) ? 6 : mi(mode);
    if (wr_en && wr_idx != 15)
      for (int m = 0; m < 7; m++)
        if (same_copy(m, wm, wr_idx)) view[m][wr_idx] = wr_data;
    if (cpsr_we) mcpsr = cpsr_wdata;
    if (spsr_we && wm >= 1 && wm <= 5) msaved[wm] = spsr_wdata;
    mq = wm;
  endtask

  initial begin
    reset_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    ra_idx = 13; rb_idx = 0;
    #2;
    check("R1", ra_data, 32'h0);
    check("R1", rb_data, 32'h0);
    check("R1", cpsr_q, 32'h0);
    check("R1", {31'b0, spsr_present}, 32'h1);
    check("R1", spsr_q, 32'h0);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) mode = CODES[$urandom_range(0, 7)];
      pc_in      = $urandom;
      ra_idx     = 4'($urandom_range(0, 15));
      rb_idx     = 4'($urandom_range(0, 15));
      wr_en      = $urandom_range(0, 9) < 6;
      wr_idx     = ($urandom_range(0, 3) == 0) ? ra_idx : 4'($urandom_range(0, 15));
      wr_data    = $urandom;
      cpsr_we    = $urandom_range(0, 9) < 2;
      cpsr_wdata = $urandom;
      spsr_we    = $urandom_range(0, 9) < 3;
      spsr_wdata = $urandom;
      spsr_rd    = $urandom_range(0, 1) == 1;
      #2;
      compare();
      @(posedge clk);
      update();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule